// File: doc/BRIEF.md
# Per-Reference Partial Mode Decision Engine

This engine sits behind a motion-estimation datapath that evaluates one search candidate per cycle for a single current macroblock inside a single reference frame. With every candidate, the datapath presents a motion vector and the distortion (SAD) of all 41 partition blocks at that displacement. The engine adds an estimated motion-vector cost to each distortion value. It keeps the cheapest candidate for each partition, independently of the other partitions.

The motion-vector cost uses a predictor and a Lagrangian weight that are captured when the sweep starts. The predictor is an approximation formed from information that already exists, because the exact predictor is not yet known in this processing order. When the candidate marked as last has been taken in, the engine streams out one record per partition in ascending partition order and then raises a completion pulse. A later stage combines these records across modes and reference frames. Each sweep starts from a clean slate.

Top module: `pmd_engine`

## Requirements
- R1: While `rst` is high and in the cycles after it until a sweep ends, `res_valid` and `done` stay low.
- R2: The cost of a candidate for partition p is SAD[p] + lambda*(|mvx-pmvx| + |mvy-pmvy|). MVs and predictors are 8-bit two's complement, lambda is 8-bit unsigned, the SAD of partition p sits at `cand_sad[p*16 +: 16]`, and the cost is 19 bits wide with no wrap.
- R3: For each of the 41 partitions, the record emitted after a sweep holds the minimum cost over all accepted candidates of that sweep, together with that candidate's MV. Each partition is decided on its own.
- R4: When a later candidate's cost equals the stored best, the earlier candidate's MV and cost are kept.
- R5: Lambda and predictor are sampled only in the cycle a sweep is started. Changes to `start_lambda`, `start_pmvx` and `start_pmvy` afterwards have no effect on the emitted costs or MVs.
- R6: Cycles with `cand_valid` low are ignored, whatever the values on the SAD and MV inputs.
- R7: Acceptance of a candidate with `cand_last` high ends the sweep. In the following cycle, `res_valid` rises for 41 consecutive cycles with `res_idx` counting 0 to 40. The index order is: 0 = 16x16; 1-2 = 16x8; 3-4 = 8x16; 5-8 = 8x8; 9-16 = 8x4; 17-24 = 4x8; 25-40 = 4x4.
- R8: `done` is high for exactly one cycle, in the cycle right after the record with index 40, and never together with `res_valid`.
- R9: A `start` pulse during a sweep or during emission is ignored. It neither clears the stored best values nor replaces lambda or the predictor.
- R10: A new sweep does not inherit best values from an earlier sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when the engine is idle |
| start_lambda | input | 8 | MV cost weight, sampled with start |
| start_pmvx | input | 8 | Estimated predictor, horizontal, signed |
| start_pmvy | input | 8 | Estimated predictor, vertical, signed |
| cand_valid | input | 1 | Candidate present this cycle |
| cand_last | input | 1 | Marks the final candidate of the sweep |
| cand_mvx | input | 8 | Candidate MV horizontal, signed |
| cand_mvy | input | 8 | Candidate MV vertical, signed |
| cand_sad | input | 656 | 41 SAD fields of 16 bits, partition p at bits p*16 |
| res_valid | output | 1 | Result record valid |
| res_idx | output | 6 | Partition index of the record |
| res_mvx | output | 8 | Winning MV horizontal |
| res_mvy | output | 8 | Winning MV vertical |
| res_cost | output | 19 | Winning cost |
| done | output | 1 | One-cycle completion pulse |

## Verification
The stored best values are invisible until the sweep ends. A corrupted best-cost slot, a missed clear or a wrong tie decision therefore shows up only in the emission burst, on the record of the affected partition, which appears between 1 and 41 cycles after the last candidate. A fault in the sequencer shows at once: `res_valid`, `res_idx` or `done` goes wrong in the first cycle that it misbehaves. The bench therefore compares every output on every cycle against a behavioural model, so that a wrong partition is named by its index.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    localparam int NPART  = 41;
    localparam int SAD_W  = 16;
    localparam int MV_W   = 8;
    localparam int LAM_W  = 8;
    localparam int MVC_W  = MV_W + 2 + LAM_W;
    localparam int COST_W = ((SAD_W > MVC_W) ? SAD_W : MVC_W) + 1;
    localparam int IDX_W  = $clog2(NPART);

    typedef struct packed {
        logic signed [MV_W-1:0] x;
        logic signed [MV_W-1:0] y;
    } mv_t;

    typedef struct packed {
        logic [COST_W-1:0] cost;
        mv_t               mv;
    } best_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SWEEP = 2'd1,
        PH_EMIT  = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    // magnitude of the difference of two signed vector components
    function automatic logic [MV_W:0] abs_diff(logic signed [MV_W-1:0] a,
                                               logic signed [MV_W-1:0] b);
        logic signed [MV_W:0] d;
        d = {a[MV_W-1], a} - {b[MV_W-1], b};
        return d[MV_W] ? $unsigned(-d) : $unsigned(d);
    endfunction

    // weighted L1 distance of a candidate vector from the predictor
    function automatic logic [MVC_W-1:0] mv_cost(mv_t c, mv_t p,
                                                 logic [LAM_W-1:0] lam);
        logic [MV_W+1:0] s;
        s = {1'b0, abs_diff(c.x, p.x)} + {1'b0, abs_diff(c.y, p.y)};
        return MVC_W'(s) * MVC_W'(lam);
    endfunction

endpackage

// File: rtl/pmd_mvcost.sv
module pmd_mvcost
    import pmd_pkg::*;
(
    input  mv_t              cand_mv,
    input  mv_t              pred_mv,
    input  logic [LAM_W-1:0] lambda,
    output logic [MVC_W-1:0] mvc
);

    always_comb begin
        mvc = mv_cost(cand_mv, pred_mv, lambda);
    end

endmodule

// File: rtl/pmd_best_slot.sv
module pmd_best_slot
    import pmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd_en,
    input  logic [SAD_W-1:0] sad,
    input  logic [MVC_W-1:0] mvc,
    input  mv_t              mv,
    output best_t            best
);

    logic              have_q;
    best_t             best_q;
    logic [COST_W-1:0] cand_cost;
    logic              take;

    always_comb begin
        cand_cost = COST_W'(sad) + COST_W'(mvc);
        // strict less-than keeps the earlier candidate on a tie
        take      = upd_en && (!have_q || (cand_cost < best_q.cost));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 1'b0;
            best_q <= '0;
        end else if (clr) begin
            have_q <= 1'b0;
        end else if (take) begin
            have_q      <= 1'b1;
            best_q.cost <= cand_cost;
            best_q.mv   <= mv;
        end
    end

    assign best = best_q;

    // stored best never gets worse within a sweep
    assert_best_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        (have_q && $past(have_q) && !$past(clr)) |-> (best_q.cost <= $past(best_q.cost)));

    // an equal-cost candidate leaves the stored vector alone
    assert_tie_keeps_first_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_en && have_q && (cand_cost == best_q.cost)) && !$past(clr))
            |-> (best_q.mv == $past(best_q.mv)));

endmodule

// File: rtl/pmd_seq.sv
module pmd_seq
    import pmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cand_valid,
    input  logic             cand_last,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             clr,
    output logic             lat_en,
    output logic             upd_en
);

    phase_e           phase_q;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        lat_en = (phase_q == PH_IDLE) && start;
        clr    = lat_en;
        upd_en = (phase_q == PH_SWEEP) && cand_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) phase_q <= PH_SWEEP;
                end
                PH_SWEEP: begin
                    if (cand_valid && cand_last) begin
                        phase_q <= PH_EMIT;
                        idx_q   <= '0;
                    end
                end
                PH_EMIT: begin
                    if (idx_q == IDX_W'(NPART - 1)) phase_q <= PH_DONE;
                    else                            idx_q   <= idx_q + 1'b1;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign idx   = idx_q;

    assert_emit_begins_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_q == PH_SWEEP && cand_valid && cand_last))
            |-> (phase_q == PH_EMIT && idx_q == '0));

    assert_idx_steps_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EMIT && $past(phase_q) == PH_EMIT)
            |-> (idx_q == $past(idx_q) + 1'b1));

    assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE)
            |-> ($past(phase_q) == PH_EMIT && $past(idx_q) == IDX_W'(NPART - 1)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

    assert_no_clear_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> !clr);

endmodule

// File: rtl/pmd_engine.sv
module pmd_engine
    import pmd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [LAM_W-1:0]          start_lambda,
    input  logic signed [MV_W-1:0]    start_pmvx,
    input  logic signed [MV_W-1:0]    start_pmvy,
    input  logic                      cand_valid,
    input  logic                      cand_last,
    input  logic signed [MV_W-1:0]    cand_mvx,
    input  logic signed [MV_W-1:0]    cand_mvy,
    input  logic [NPART*SAD_W-1:0]    cand_sad,
    output logic                      res_valid,
    output logic [IDX_W-1:0]          res_idx,
    output logic signed [MV_W-1:0]    res_mvx,
    output logic signed [MV_W-1:0]    res_mvy,
    output logic [COST_W-1:0]         res_cost,
    output logic                      done
);

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             clr, lat_en, upd_en;

    logic [LAM_W-1:0] lam_q;
    mv_t              pred_q;
    mv_t              cand_mv;
    logic [MVC_W-1:0] mvc;
    best_t            best [NPART];
    best_t            sel;

    pmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cand_valid (cand_valid),
        .cand_last  (cand_last),
        .phase      (phase),
        .idx        (idx),
        .clr        (clr),
        .lat_en     (lat_en),
        .upd_en     (upd_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lam_q  <= '0;
            pred_q <= '0;
        end else if (lat_en) begin
            lam_q    <= start_lambda;
            pred_q.x <= start_pmvx;
            pred_q.y <= start_pmvy;
        end
    end

    always_comb begin
        cand_mv.x = cand_mvx;
        cand_mv.y = cand_mvy;
    end

    // one vector cost serves every partition of the candidate
    pmd_mvcost u_mvc (
        .cand_mv (cand_mv),
        .pred_mv (pred_q),
        .lambda  (lam_q),
        .mvc     (mvc)
    );

    for (genvar p = 0; p < NPART; p++) begin : g_slot
        pmd_best_slot u_slot (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .upd_en (upd_en),
            .sad    (cand_sad[p*SAD_W +: SAD_W]),
            .mvc    (mvc),
            .mv     (cand_mv),
            .best   (best[p])
        );
    end

    always_comb begin
        sel = '0;
        for (int p = 0; p < NPART; p++) begin
            if (idx == IDX_W'(p)) sel = best[p];
        end
    end

    always_comb begin
        res_valid = (phase == PH_EMIT);
        res_idx   = idx;
        res_mvx   = sel.mv.x;
        res_mvy   = sel.mv.y;
        res_cost  = sel.cost;
        done      = (phase == PH_DONE);
    end

    assert_weights_held_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(lat_en) |-> (lam_q == $past(lam_q) && pred_q == $past(pred_q)));

    assert_valid_done_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && done));

endmodule

// File: tb/pmd_engine_tb_top.sv
module pmd_engine_tb_top;
    import pmd_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   start;
    logic [LAM_W-1:0]       start_lambda;
    logic signed [MV_W-1:0] start_pmvx, start_pmvy;
    logic                   cand_valid, cand_last;
    logic signed [MV_W-1:0] cand_mvx, cand_mvy;
    logic [NPART*SAD_W-1:0] cand_sad;
    logic                   res_valid, done;
    logic [IDX_W-1:0]       res_idx;
    logic signed [MV_W-1:0] res_mvx, res_mvy;
    logic [COST_W-1:0]      res_cost;

    always #2.5 clk = ~clk;

    pmd_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .start_lambda(start_lambda),
        .start_pmvx(start_pmvx), .start_pmvy(start_pmvy),
        .cand_valid(cand_valid), .cand_last(cand_last),
        .cand_mvx(cand_mvx), .cand_mvy(cand_mvy), .cand_sad(cand_sad),
        .res_valid(res_valid), .res_idx(res_idx), .res_mvx(res_mvx),
        .res_mvy(res_mvy), .res_cost(res_cost), .done(done)
    );

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    string cur_req = "R3";

    // behavioural reference model
    int m_phase = 0;
    int m_idx   = 0;
    int m_lam   = 0;
    int m_px    = 0;
    int m_py    = 0;
    int m_cost [NPART];
    int m_mvx  [NPART];
    int m_mvy  [NPART];
    bit m_have [NPART];

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0;
            m_idx   = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                    m_lam = int'(start_lambda);
                    m_px  = int'(start_pmvx);
                    m_py  = int'(start_pmvy);
                    for (int p = 0; p < NPART; p++) m_have[p] = 1'b0;
                    m_phase = 1;
                end
                1: if (cand_valid) begin
                    for (int p = 0; p < NPART; p++) begin
                        int c;
                        c = int'(cand_sad[p*SAD_W +: SAD_W]) +
                            m_lam * (iabs(int'(cand_mvx) - m_px) + iabs(int'(cand_mvy) - m_py));
                        if (!m_have[p] || c < m_cost[p]) begin
                            m_have[p] = 1'b1;
                            m_cost[p] = c;
                            m_mvx[p]  = int'(cand_mvx);
                            m_mvy[p]  = int'(cand_mvy);
                        end
                    end
                    if (cand_last) begin
                        m_phase = 2;
                        m_idx   = 0;
                    end
                end
                2: if (m_idx == NPART - 1) m_phase = 3; else m_idx++;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (!rst) begin
            chk("R7 res_valid", int'(res_valid), int'(m_phase == 2));
            chk("R8 done", int'(done), int'(m_phase == 3));
            if (m_phase == 2) begin
                chk("R7 res_idx", int'(res_idx), m_idx);
                chk({cur_req, " cost"}, int'(res_cost), m_cost[m_idx]);
                chk({cur_req, " mvx"}, int'(res_mvx), m_mvx[m_idx]);
                chk({cur_req, " mvy"}, int'(res_mvy), m_mvy[m_idx]);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic go(int lam, int px, int py);
        start        = 1'b1;
        start_lambda = LAM_W'(lam);
        start_pmvx   = MV_W'(px);
        start_pmvy   = MV_W'(py);
        tick();
        start = 1'b0;
    endtask

    // mode 0: random SADs, 1: all equal to base, 2: base + 10*p
    task automatic cand(int mx, int my, bit last, int mode, int base);
        for (int p = 0; p < NPART; p++) begin
            int v;
            v = (mode == 0) ? int'($urandom_range(0, 3000)) :
                (mode == 1) ? base : base + 10 * p;
            cand_sad[p*SAD_W +: SAD_W] = SAD_W'(v);
        end
        cand_mvx   = MV_W'(mx);
        cand_mvy   = MV_W'(my);
        cand_last  = last;
        cand_valid = 1'b1;
        tick();
        cand_valid = 1'b0;
        cand_last  = 1'b0;
    endtask

    // idle cycles with junk on the data inputs (R6)
    task automatic gap(int n);
        for (int i = 0; i < n; i++) begin
            cand_sad  = '0;
            cand_mvx  = MV_W'($urandom_range(0, 255));
            cand_mvy  = MV_W'($urandom_range(0, 255));
            cand_last = 1'b1;
            tick();
        end
        cand_last = 1'b0;
    endtask

    task automatic drain();
        while (m_phase != 0) tick();
        tick();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; start_lambda = '0; start_pmvx = '0; start_pmvy = '0;
        cand_valid = 1'b0; cand_last = 1'b0; cand_mvx = '0; cand_mvy = '0; cand_sad = '0;
        repeat (4) tick();
        chk("R1 res_valid in reset", int'(res_valid), 0);
        chk("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        repeat (3) tick();
        chk("R1 res_valid idle", int'(res_valid), 0);
        chk("R1 done idle", int'(done), 0);

        // R2: a single candidate gives the plain cost formula
        cur_req = "R2";
        go(3, 2, -1);
        cand(5, 3, 1'b1, 2, 100);
        chk("R2 first record cost", int'(res_cost), 100 + 3 * (3 + 4));
        drain();

        // R2: extremes of vector and weight
        go(255, -128, 127);
        cand(127, -128, 1'b1, 1, 65535);
        chk("R2 extreme cost", int'(res_cost), 65535 + 255 * (255 + 255));
        drain();

        // R3: random sweeps, independent per partition
        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            go(int'($urandom_range(0, 15)), int'($urandom_range(0, 40)) - 20,
               int'($urandom_range(0, 40)) - 20);
            for (int k = 0; k < 30; k++)
                cand(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                     k == 29, 0, 0);
            drain();
        end

        // R4: ties keep the earliest vector
        cur_req = "R4";
        go(0, 0, 0);
        cand(7, 7, 1'b0, 1, 500);
        cand(-3, 9, 1'b0, 1, 500);
        cand(1, -1, 1'b1, 1, 500);
        chk("R4 tie keeps first mvx", int'(res_mvx), 7);
        drain();

        // R5: weight and predictor inputs change mid-sweep
        cur_req = "R5";
        go(2, 0, 0);
        start_lambda = 8'd200; start_pmvx = 8'sd100; start_pmvy = -8'sd100;
        for (int k = 0; k < 10; k++)
            cand(k - 5, 5 - k, k == 9, 0, 0);
        drain();

        // R6: idle cycles carry junk that must not count
        cur_req = "R6";
        go(1, 0, 0);
        cand(4, 4, 1'b0, 1, 800);
        gap(5);
        cand(-2, 0, 1'b1, 1, 900);
        chk("R6 best after gaps", int'(res_cost), 808);
        drain();

        // R9: start pulses while busy are ignored
        cur_req = "R9";
        go(4, 1, 1);
        cand(1, 1, 1'b0, 2, 50);
        go(0, 0, 0);
        cand(30, 30, 1'b1, 2, 60);
        tick();
        start = 1'b1; start_lambda = 8'd9;
        tick();
        start = 1'b0;
        drain();

        // R10: a new sweep starts from scratch
        cur_req = "R10";
        go(0, 0, 0);
        cand(3, 3, 1'b1, 1, 10);
        drain();
        go(0, 0, 0);
        cand(-6, 2, 1'b1, 1, 4000);
        chk("R10 no carry-over cost", int'(res_cost), 4000);
        chk("R10 no carry-over mvx", int'(res_mvx), -6);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule